// File: doc/BRIEF.md
# Selectable Bipolar Zero-Substitution Line Encoder

This block turns a serial transmit bit stream into two rails, one for positive pulses and one for negative pulses. Each bit period is marked by a one-cycle `tx_vld` strobe. A two-bit `code_sel` input picks the coding at runtime. Plain alternate-mark inversion sends every one as a pulse of the opposite sign to the pulse before it. The eight-zero substitution mode replaces each run of eight zeros with a fixed pattern of violations (V) and bipolar pulses (B). The four-zero substitution mode replaces each run of four zeros with 000V or B00V, chosen by the parity of bipolar pulses sent since the last violation. That choice keeps successive violations alternating in sign.

Bits pass through a lookahead shift register of `LA_DEPTH` stages, so a whole zero run is visible before any of it leaves. A sequencer at the tail of the buffer decides, one bit at a time, what each bit becomes: a space, a bipolar mark or a violation. A polarity stage then turns that symbol into a rail pulse, keeping the sign of the last pulse and the parity of marks since the last violation. `rail_inv` flips both rails to active-low without touching any state.

The sequencer states are FILL, PASS, SUB8 and SUB4. After reset it sits in FILL until `LA_DEPTH` strobes have filled the buffer, then moves to PASS. In PASS it moves to SUB8 when eight-zero mode is selected and the eight oldest bits are all zero. It moves to SUB4 when four-zero mode is selected and the four oldest bits are all zero. In every other case it stays in PASS and forwards the tail bit as a mark or a space. SUB8 walks steps 1..7 and SUB4 walks steps 1..3, one step per strobe, and each returns to PASS after its last step. Every transition happens only on a strobe.

Top module: `zcode_line_enc`

## Requirements
- R1: With `code_sel` = 2'b00, each one goes out as a single pulse whose sign is opposite to the previous pulse, and each zero goes out as no pulse on either rail.
- R2: With `code_sel` = 2'b01, eight zeros whose preceding pulse was positive go out as 0,0,0,+,-,0,-,+. After the pattern, the next one goes out negative.
- R3: With `code_sel` = 2'b01, eight zeros whose preceding pulse was negative go out as 0,0,0,-,+,0,+,-. After the pattern, the next one goes out positive.
- R4: With `code_sel` = 2'b10, each run of four zeros goes out as 000V when an odd number of bipolar pulses has been sent since the last violation, and as B00V when that number is even. V carries the sign of the pulse just before it, and B the opposite sign.
- R5: `code_sel` 2'b11 behaves exactly like 2'b00. The mode is sampled only when a substitution starts, and a substitution that has started always completes, even if `code_sel` changes.
- R6: With `rail_inv` = 0 the rails are active-high. With `rail_inv` = 1 both rails are inverted, with immediate (combinational) effect, including during reset.
- R7: A bit accepted on strobe k appears on the rails right after strobe k+`LA_DEPTH`. The first `LA_DEPTH` strobes after reset produce no pulse.
- R8: Reset empties the buffer, clears the violation parity to even and sets the stored last sign to negative. The first one after reset therefore goes out positive.
- R9: The positive and negative rails are never both asserted in the same bit period.
- R10: When `tx_vld` is low, the rails and all internal state hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit | input | 1 | Serial transmit data bit |
| tx_vld | input | 1 | Bit-period strobe; accepts `tx_bit` and advances the output |
| code_sel | input | 2 | 00 and 11 AMI, 01 eight-zero substitution, 10 four-zero substitution |
| rail_inv | input | 1 | 0 for active-high rails, 1 for active-low rails |
| rail_p | output | 1 | Positive pulse rail |
| rail_n | output | 1 | Negative pulse rail |

## Verification
The bench builds the encoder with the default `LA_DEPTH` of 8, the smallest depth that holds a full eight-zero run. At that depth, a 32-bit stimulus word exercises fill, back-to-back substitutions, leftover zeros after a run, and a run that starts straight out of reset, where the first pulse is a negative violation. The vector table and the hand-worked sequences cover both signs of the preceding pulse, both four-zero substitution choices, and a mode switch in the middle of a substitution. Strobe gaps show that the rails hold between bit periods.

// File: rtl/zcode_pkg.sv
package zcode_pkg;

    typedef enum logic [1:0] {
        CODE_AMI     = 2'b00,
        CODE_SUB8    = 2'b01,
        CODE_SUB4    = 2'b10,
        CODE_AMI_ALT = 2'b11
    } code_e;

    typedef enum logic [1:0] {
        SYM_SPACE = 2'b00,
        SYM_MARK  = 2'b01,
        SYM_VIOL  = 2'b10
    } sym_e;

    typedef enum logic [1:0] {
        ST_FILL = 2'b00,
        ST_PASS = 2'b01,
        ST_SUB8 = 2'b10,
        ST_SUB4 = 2'b11
    } seq_state_e;

    localparam int LONG_RUN  = 8;
    localparam int SHORT_RUN = 4;
    localparam int STEP_W    = $clog2(LONG_RUN);

    // Eight-zero pattern: violations at steps 3 and 6, bipolar marks at 4 and 7.
    function automatic sym_e sub8_sym(input logic [STEP_W-1:0] step);
        sym_e s;
        case (step)
            3'd3, 3'd6: s = SYM_VIOL;
            3'd4, 3'd7: s = SYM_MARK;
            default:    s = SYM_SPACE;
        endcase
        return s;
    endfunction

    // Four-zero pattern: optional leading mark, violation at step 3.
    function automatic sym_e sub4_sym(input logic [STEP_W-1:0] step, input logic lead_b);
        sym_e s;
        if (step == 3'd3) begin
            s = SYM_VIOL;
        end else if (step == 3'd0 && lead_b) begin
            s = SYM_MARK;
        end else begin
            s = SYM_SPACE;
        end
        return s;
    endfunction

endpackage

// File: rtl/zlook_buf.sv
module zlook_buf #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic tail_bit,
    output logic long_zero,
    output logic short_zero
);
    import zcode_pkg::*;

    localparam int TOP = DEPTH - 1;

    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {sr[DEPTH-2:0], bit_in};
        end
    end

    assign tail_bit   = sr[TOP];
    assign long_zero  = ~|sr[TOP -: LONG_RUN];
    assign short_zero = ~|sr[TOP -: SHORT_RUN];

endmodule

// File: rtl/zsub_seq.sv
module zsub_seq #(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [1:0]        code_sel,
    input  logic              tail_bit,
    input  logic              long_zero,
    input  logic              short_zero,
    input  logic              par_even,
    output zcode_pkg::sym_e   sym
);
    import zcode_pkg::*;

    localparam int FILL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(DEPTH - 1);
    localparam logic [STEP_W-1:0] SUB8_LAST = STEP_W'(LONG_RUN - 1);
    localparam logic [STEP_W-1:0] SUB4_LAST = STEP_W'(SHORT_RUN - 1);

    seq_state_e          state, nxt_state;
    logic [STEP_W-1:0]   step, nxt_step;
    logic [FILL_W-1:0]   fill_cnt, nxt_fill;
    logic                lead_b, nxt_lead;
    code_e               code;
    logic                go8, go4;

    assign code = code_e'(code_sel);
    assign go8  = (code == CODE_SUB8) && long_zero;
    assign go4  = (code == CODE_SUB4) && short_zero;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            step     <= '0;
            fill_cnt <= '0;
            lead_b   <= 1'b0;
        end else if (strobe) begin
            state    <= nxt_state;
            step     <= nxt_step;
            fill_cnt <= nxt_fill;
            lead_b   <= nxt_lead;
        end
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_step  = step;
        nxt_fill  = fill_cnt;
        nxt_lead  = lead_b;
        unique case (state)
            ST_FILL: begin
                nxt_fill = fill_cnt + 1'b1;
                if (fill_cnt == FILL_LAST) begin
                    nxt_state = ST_PASS;
                    nxt_fill  = '0;
                end
            end
            ST_PASS: begin
                if (go8) begin
                    nxt_state = ST_SUB8;
                    nxt_step  = STEP_W'(1);
                end else if (go4) begin
                    nxt_state = ST_SUB4;
                    nxt_step  = STEP_W'(1);
                    nxt_lead  = par_even;
                end
            end
            ST_SUB8: begin
                if (step == SUB8_LAST) begin
                    nxt_state = ST_PASS;
                    nxt_step  = '0;
                end else begin
                    nxt_step = step + 1'b1;
                end
            end
            ST_SUB4: begin
                if (step == SUB4_LAST) begin
                    nxt_state = ST_PASS;
                    nxt_step  = '0;
                end else begin
                    nxt_step = step + 1'b1;
                end
            end
        endcase
    end

    // Output logic: symbol for the bit leaving the buffer on this strobe
    always_comb begin
        sym = SYM_SPACE;
        unique case (state)
            ST_FILL: sym = SYM_SPACE;
            ST_PASS: begin
                if (go8) begin
                    sym = sub8_sym('0);
                end else if (go4) begin
                    sym = sub4_sym('0, par_even);
                end else begin
                    sym = tail_bit ? SYM_MARK : SYM_SPACE;
                end
            end
            ST_SUB8: sym = sub8_sym(step);
            ST_SUB4: sym = sub4_sym(step, lead_b);
        endcase
    end

endmodule

// File: rtl/pulse_pol.sv
module pulse_pol (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  zcode_pkg::sym_e sym,
    output logic            pos_q,
    output logic            neg_q,
    output logic            par_even
);
    import zcode_pkg::*;

    logic last_pos;
    logic odd_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q    <= 1'b0;
            neg_q    <= 1'b0;
            last_pos <= 1'b0;
            odd_b    <= 1'b0;
        end else if (strobe) begin
            unique case (sym)
                SYM_MARK: begin
                    pos_q    <= ~last_pos;
                    neg_q    <= last_pos;
                    last_pos <= ~last_pos;
                    odd_b    <= ~odd_b;
                end
                SYM_VIOL: begin
                    pos_q <= last_pos;
                    neg_q <= ~last_pos;
                    odd_b <= 1'b0;
                end
                default: begin
                    pos_q <= 1'b0;
                    neg_q <= 1'b0;
                end
            endcase
        end
    end

    assign par_even = ~odd_b;

endmodule

// File: rtl/zcode_line_enc.sv
module zcode_line_enc #(
    parameter int LA_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_bit,
    input  logic       tx_vld,
    input  logic [1:0] code_sel,
    input  logic       rail_inv,
    output logic       rail_p,
    output logic       rail_n
);
    import zcode_pkg::*;

    logic tail_bit, long_zero, short_zero;
    logic par_even;
    logic pos_q, neg_q;
    sym_e sym;

    zlook_buf #(.DEPTH(LA_DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (tx_vld),
        .bit_in    (tx_bit),
        .tail_bit  (tail_bit),
        .long_zero (long_zero),
        .short_zero(short_zero)
    );

    zsub_seq #(.DEPTH(LA_DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (tx_vld),
        .code_sel  (code_sel),
        .tail_bit  (tail_bit),
        .long_zero (long_zero),
        .short_zero(short_zero),
        .par_even  (par_even),
        .sym       (sym)
    );

    pulse_pol u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (tx_vld),
        .sym     (sym),
        .pos_q   (pos_q),
        .neg_q   (neg_q),
        .par_even(par_even)
    );

    assign rail_p = pos_q ^ rail_inv;
    assign rail_n = neg_q ^ rail_inv;

endmodule

// File: rtl/zcode_line_enc_chk.sv
module zcode_line_enc_chk #(
    parameter int LA_DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic tx_vld,
    input logic rail_inv,
    input logic rail_p,
    input logic rail_n
);
    localparam int CNT_W = $clog2(LA_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LA_DEPTH);

    logic lp, ln;
    logic [CNT_W-1:0] seen_cnt;

    assign lp = rail_p ^ rail_inv;
    assign ln = rail_n ^ rail_inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_cnt <= '0;
        end else if (tx_vld && seen_cnt < CNT_MAX) begin
            seen_cnt <= seen_cnt + 1'b1;
        end
    end

    assert_rails_exclusive_R9: assert property (
        @(posedge clk) disable iff (!rst_n) !(lp && ln));

    assert_hold_idle_R10: assert property (
        @(posedge clk) disable iff (!rst_n) !tx_vld |=> ($stable(lp) && $stable(ln)));

    assert_reset_level_R6: assert property (
        @(posedge clk) !rst_n |-> (rail_p == rail_inv && rail_n == rail_inv));

    assert_fill_quiet_R7: assert property (
        @(posedge clk) disable iff (!rst_n) (tx_vld && seen_cnt < CNT_MAX) |=> (!lp && !ln));

endmodule

bind zcode_line_enc zcode_line_enc_chk #(.LA_DEPTH(LA_DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_vld  (tx_vld),
    .rail_inv(rail_inv),
    .rail_p  (rail_p),
    .rail_n  (rail_n)
);

// File: tb/sim_zcode_line_enc.sv
module sim_zcode_line_enc;

    localparam int CLK_PERIOD = 10;
    localparam int LAT  = 8;
    localparam int NBIT = 32;
    localparam int NOUT = NBIT - LAT;

    typedef struct packed {
        logic [1:0]  mode;
        logic        inv;
        logic        gap;
        logic [31:0] pat;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 1'b0, 32'hB3A5_0F81},
        '{2'b11, 1'b1, 1'b1, 32'h8000_0C01},
        '{2'b01, 1'b0, 1'b0, 32'h8000_2001},
        '{2'b01, 1'b1, 1'b1, 32'hC000_0001},
        '{2'b10, 1'b0, 1'b0, 32'h8000_0000},
        '{2'b10, 1'b1, 1'b0, 32'h9087_0421},
        '{2'b10, 1'b0, 1'b1, 32'h0000_0000},
        '{2'b01, 1'b0, 1'b0, 32'h0000_0000}
    };

    // Hand-worked rail sequences (+1 positive, -1 negative, 0 none)
    localparam int H_R2  [11] = '{1, 0, 0, 0, 1, -1, 0, -1, 1, -1, 1};
    localparam int H_R3  [11] = '{1, -1, 0, 0, 0, -1, 1, 0, 1, -1, 1};
    localparam int H_R4  [11] = '{1, 0, 0, 0, 1, -1, 0, 0, -1, 1, -1};
    localparam int H_R1  [11] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, -1, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_bit = 1'b0;
    logic       tx_vld = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic       rail_inv = 1'b0;
    logic       rail_p, rail_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int got [NBIT];
    int exp_s [NOUT];

    always #(CLK_PERIOD/2) clk = ~clk;

    zcode_line_enc #(.LA_DEPTH(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .tx_vld(tx_vld),
        .code_sel(code_sel), .rail_inv(rail_inv), .rail_p(rail_p), .rail_n(rail_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int enc(input logic p, input logic n);
        if (p && n) return 2;
        if (p) return 1;
        if (n) return -1;
        return 0;
    endfunction

    task automatic do_reset(input logic inv);
        rst_n = 1'b0;
        tx_vld = 1'b0;
        tx_bit = 1'b0;
        rail_inv = inv;
        repeat (2) @(posedge clk);
        #1;
        // R6 / R8: no pulse during reset, rails at the inactive level
        chk(rail_p == inv && rail_n == inv, "R6 reset level",
            int'({rail_p, rail_n}), int'({inv, inv}));
        rst_n = 1'b1;
    endtask

    task automatic feed(input logic [1:0] mode, input logic inv, input logic [31:0] pat,
                        input logic gap, input int sw_at);
        code_sel = mode;
        do_reset(inv);
        for (int k = 0; k < NBIT; k++) begin
            tx_bit = pat[31-k];
            tx_vld = 1'b1;
            if (k >= sw_at) code_sel = 2'b00;
            @(posedge clk);
            #1;
            got[k] = enc(rail_p ^ inv, rail_n ^ inv);
            if (gap) begin
                logic hp, hn;
                hp = rail_p;
                hn = rail_n;
                tx_vld = 1'b0;
                tx_bit = ~tx_bit;
                @(posedge clk);
                #1;
                chk(rail_p == hp && rail_n == hn, "R10 hold while idle",
                    int'({rail_p, rail_n}), int'({hp, hn}));
            end
        end
        tx_vld = 1'b0;
    endtask

    function automatic bit zeros(input logic [31:0] pat, input int i, input int n);
        for (int j = i; j < i + n; j++) begin
            if (j > 31) return 1'b0;
            if (pat[31-j]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic ref_encode(input logic [1:0] mode, input logic [31:0] pat);
        int  last;
        bit  odd;
        int  rem;
        int  kind;
        int  pos;
        bit  leadb;
        int  s;
        last = -1; odd = 1'b0; rem = 0; kind = 0; pos = 0; leadb = 1'b0;
        for (int i = 0; i < NOUT; i++) begin
            if (rem == 0) begin
                if (mode == 2'b01 && zeros(pat, i, 8)) begin
                    kind = 1; rem = 8; pos = 0;
                end else if (mode == 2'b10 && zeros(pat, i, 4)) begin
                    kind = 2; rem = 4; pos = 0; leadb = !odd;
                end
            end
            if (rem > 0) begin
                if (kind == 1) s = (pos == 3 || pos == 6) ? 2 : ((pos == 4 || pos == 7) ? 1 : 0);
                else           s = (pos == 3) ? 2 : ((pos == 0 && leadb) ? 1 : 0);
                pos++;
                rem--;
            end else begin
                s = pat[31-i] ? 1 : 0;
            end
            if (s == 1) begin
                last = -last; exp_s[i] = last; odd = !odd;
            end else if (s == 2) begin
                exp_s[i] = last; odd = 1'b0;
            end else begin
                exp_s[i] = 0;
            end
        end
    endtask

    task automatic check_model(input logic [1:0] mode, input logic [31:0] pat, input string tag);
        ref_encode(mode, pat);
        for (int k = 0; k < LAT; k++)
            chk(got[k] == 0, "R7 fill quiet", got[k], 0);
        for (int i = 0; i < NOUT; i++)
            chk(got[i+LAT] == exp_s[i], tag, got[i+LAT], exp_s[i]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            case (VECS[v].mode)
                2'b01:   tag = "R2 R3 R7 eight-zero vs model";
                2'b10:   tag = "R4 R7 four-zero vs model";
                2'b11:   tag = "R5 R1 alt AMI code vs model";
                default: tag = "R1 R7 AMI vs model";
            endcase
            feed(VECS[v].mode, VECS[v].inv, VECS[v].pat, VECS[v].gap, NBIT);
            check_model(VECS[v].mode, VECS[v].pat, tag);
        end

        // R2: preceding pulse positive
        feed(2'b01, 1'b0, 32'h807F_FFFF, 1'b0, NBIT);
        for (int i = 0; i < 11; i++) chk(got[LAT+i] == H_R2[i], "R2 after positive", got[LAT+i], H_R2[i]);

        // R3: preceding pulse negative
        feed(2'b01, 1'b1, 32'hC03F_FFFF, 1'b0, NBIT);
        for (int i = 0; i < 11; i++) chk(got[LAT+i] == H_R3[i], "R3 after negative", got[LAT+i], H_R3[i]);

        // R4: 000V then B00V
        feed(2'b10, 1'b0, 32'h807F_FFFF, 1'b0, NBIT);
        for (int i = 0; i < 11; i++) chk(got[LAT+i] == H_R4[i], "R4 four-zero choice", got[LAT+i], H_R4[i]);

        // R1 and R8: plain alternation, first one positive
        feed(2'b00, 1'b0, 32'h807F_FFFF, 1'b0, NBIT);
        for (int i = 0; i < 11; i++) chk(got[LAT+i] == H_R1[i], "R1 R8 AMI first mark", got[LAT+i], H_R1[i]);

        // R5: code 11 equals AMI
        feed(2'b11, 1'b0, 32'h807F_FFFF, 1'b1, NBIT);
        for (int i = 0; i < 11; i++) chk(got[LAT+i] == H_R1[i], "R5 code 11 as AMI", got[LAT+i], H_R1[i]);

        // R5: switch to AMI on strobe 11, inside an eight-zero substitution
        feed(2'b01, 1'b0, 32'h807F_FFFF, 1'b0, 11);
        for (int i = 0; i < 11; i++) chk(got[LAT+i] == H_R2[i], "R5 substitution completes", got[LAT+i], H_R2[i]);

        // R6: rail_inv acts combinationally on held rails
        feed(2'b00, 1'b0, 32'h0000_0080, 1'b0, NBIT);
        // input index 24 is a one, its pulse is never shifted out; last strobe output is index 23 = 0
        tx_bit = 1'b1; tx_vld = 1'b0;
        rail_inv = 1'b1;
        #1;
        chk(rail_p == 1'b1 && rail_n == 1'b1, "R6 invert idle rails", int'({rail_p, rail_n}), 3);
        rail_inv = 1'b0;
        #1;
        chk(rail_p == 1'b0 && rail_n == 1'b0, "R6 active-high idle", int'({rail_p, rail_n}), 0);

        // R9 and R7: a held pulse inverts cleanly; latency exactly LAT strobes
        do_reset(1'b0);
        code_sel = 2'b00;
        for (int k = 0; k <= LAT; k++) begin
            tx_bit = (k == 0);
            tx_vld = 1'b1;
            @(posedge clk);
            #1;
            if (k < LAT) chk(rail_p == 1'b0 && rail_n == 1'b0, "R7 not yet out", int'({rail_p, rail_n}), 0);
            else         chk(rail_p == 1'b1 && rail_n == 1'b0, "R7 R9 out after LAT", int'({rail_p, rail_n}), 2);
        end
        tx_vld = 1'b0;
        rail_inv = 1'b1;
        #1;
        chk(rail_p == 1'b0 && rail_n == 1'b1, "R6 R9 inverted pulse", int'({rail_p, rail_n}), 1);
        rail_inv = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule